// File: doc/BRIEF.md
# Count/Compare Timer Interrupt Unit

This block keeps a 32-bit counter that advances by one on every cycle in which the enable tick is high. It also holds a 32-bit compare value. When the two registers hold equal values, the block raises a timer interrupt. Software loads either register through a single write port and reads the counter through a read port. A freeze input stops the counter. While the freeze input is high, both registers can still be written, and no match can fire.

A pending-interrupt state machine has two states.

- `PS_IDLE`: no interrupt is pending.
- `PS_PEND`: an interrupt is pending.

It has two transitions.

- `T_FIRE` (`PS_IDLE` to `PS_PEND`): taken when the registers match, the freeze input is low and no compare write is in progress.
- `T_ACK` (`PS_PEND` to `PS_IDLE`): taken on any compare write.

While an interrupt is pending, it is driven on one of eight output lines. A 3-bit routing input selects the line, and that input is registered. A sticky status bit records the match, but only when the revision-feature input is high.

Top module: `cmp_timer_unit`

## Requirements
- R1: After reset the counter reads 1, compare holds 0, all interrupt lines are low, and the status bit is 0.
- R2: With freeze low, the counter increments by one on each cycle with `tick_en` high, holds when `tick_en` is low, and wraps from 0xFFFFFFFF to 0.
- R3: A counter write (`wr_en` high, `wr_sel` = 0) loads `wr_data` on the next edge and takes priority over a same-cycle increment.
- R4: When counter equals compare and freeze is low, the selected interrupt line goes high at the next edge. With the tick running, this is the same edge that moves the counter to compare+1.
- R5: A pending interrupt stays asserted as the counter moves past the match value, until compare is written or reset.
- R6: A compare write (`wr_en` high, `wr_sel` = 1) clears the pending interrupt and the status bit at the next edge. It wins over a match in the same cycle.
- R7: While freeze is high, the counter holds, counter writes still load, and a match never fires. Once freeze drops with the registers equal, the interrupt fires at the next edge.
- R8: While pending, exactly line `irq_lines[route_sel]` is high and the other lines are low. A change of `route_sel` moves the asserted line at the next edge.
- R9: The status bit is set on a match only if `rev2_en` is high. The interrupt line is asserted whatever the value of `rev2_en`.
- R10: `rd_count` always shows the current counter register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable tick |
| freeze | input | 1 | Disable-count control bit |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 counter, 1 compare |
| wr_data | input | 32 | Write data |
| route_sel | input | 3 | Interrupt line index |
| rev2_en | input | 1 | Enables the sticky status bit |
| rd_count | output | 32 | Counter read port |
| irq_lines | output | 8 | Interrupt output lines |
| ti_status | output | 1 | Sticky timer-interrupt status |

## Verification
A match and an acknowledging compare write can occur in the same cycle, and the write must win. The bench provokes this by letting the counter tick onto the compare value and issuing a compare write in that very cycle. It then judges that no line rises and the status stays clear over the following cycles. The counter write against the increment is a second collision, checked by loading a value while the tick is held high.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [0:0] {
        PS_IDLE = 1'b0,
        PS_PEND = 1'b1
    } pend_state_e;

    localparam logic WSEL_COUNT   = 1'b0;
    localparam logic WSEL_COMPARE = 1'b1;
endpackage

// File: rtl/tmr_count_reg.sv
module tmr_count_reg
    import tmr_pkg::*;
#(
    parameter int unsigned      CNT_W       = 32,
    parameter logic [CNT_W-1:0] RST_COUNT   = 1,
    parameter logic [CNT_W-1:0] RST_COMPARE = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             freeze,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count_q,
    output logic             cmp_wr,
    output logic             match
);
    logic [CNT_W-1:0] compare_q;
    logic             cnt_wr;

    assign cnt_wr = wr_en && (wr_sel == WSEL_COUNT);
    assign cmp_wr = wr_en && (wr_sel == WSEL_COMPARE);

    // Counter: a software load beats the tick increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= RST_COUNT;
        end else if (cnt_wr) begin
            count_q <= wr_data;
        end else if (!freeze && tick_en) begin
            count_q <= count_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            compare_q <= RST_COMPARE;
        end else if (cmp_wr) begin
            compare_q <= wr_data;
        end
    end

    // A match is only recognised while the counter runs.
    assign match = !freeze && (count_q == compare_q);
endmodule

// File: rtl/tmr_match_fsm.sv
module tmr_match_fsm
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic match,
    input  logic cmp_wr,
    input  logic rev2_en,
    output logic pending,
    output logic status
);
    pend_state_e state_q, state_d;
    logic        status_q, status_d;

    // Next-state logic. T_FIRE: IDLE->PEND, T_ACK: PEND->IDLE.
    always_comb begin
        state_d  = state_q;
        status_d = status_q;
        unique case (state_q)
            PS_IDLE: begin
                if (match && !cmp_wr) begin
                    state_d = PS_PEND;
                end
            end
            PS_PEND: begin
                if (cmp_wr) begin
                    state_d = PS_IDLE;
                end
            end
            default: state_d = PS_IDLE;
        endcase
        if (cmp_wr) begin
            status_d = 1'b0;
        end else if (match && rev2_en) begin
            status_d = 1'b1;
        end
    end

    // State register process.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= PS_IDLE;
            status_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            status_q <= status_d;
        end
    end

    // Output process.
    always_comb begin
        pending = (state_q == PS_PEND);
        status  = status_q;
    end
endmodule

// File: rtl/tmr_irq_route.sv
module tmr_irq_route #(
    parameter int unsigned N_LINES = 8,
    localparam int unsigned SEL_W  = $clog2(N_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] route_sel,
    input  logic             pending,
    output logic [N_LINES-1:0] irq_lines
);
    logic [SEL_W-1:0] route_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_q <= '0;
        end else begin
            route_q <= route_sel;
        end
    end

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        assign irq_lines[g] = pending && (route_q == SEL_W'(g));
    end
endmodule

// File: rtl/cmp_timer_unit.sv
module cmp_timer_unit #(
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned N_LINES = 8,
    localparam int unsigned SEL_W  = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en,
    input  logic               freeze,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [CNT_W-1:0]   wr_data,
    input  logic [SEL_W-1:0]   route_sel,
    input  logic               rev2_en,
    output logic [CNT_W-1:0]   rd_count,
    output logic [N_LINES-1:0] irq_lines,
    output logic               ti_status
);
    logic cmp_wr;
    logic match;
    logic pending;

    tmr_count_reg #(
        .CNT_W      (CNT_W),
        .RST_COUNT  (CNT_W'(1)),
        .RST_COMPARE(CNT_W'(0))
    ) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_en(tick_en),
        .freeze (freeze),
        .wr_en  (wr_en),
        .wr_sel (wr_sel),
        .wr_data(wr_data),
        .count_q(rd_count),
        .cmp_wr (cmp_wr),
        .match  (match)
    );

    tmr_match_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .match  (match),
        .cmp_wr (cmp_wr),
        .rev2_en(rev2_en),
        .pending(pending),
        .status (ti_status)
    );

    tmr_irq_route #(
        .N_LINES(N_LINES)
    ) u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .route_sel(route_sel),
        .pending  (pending),
        .irq_lines(irq_lines)
    );
endmodule

// File: rtl/cmp_timer_unit_chk.sv
module cmp_timer_unit_chk #(
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned N_LINES = 8,
    localparam int unsigned SEL_W  = $clog2(N_LINES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick_en,
    input logic               freeze,
    input logic               wr_en,
    input logic               wr_sel,
    input logic [CNT_W-1:0]   wr_data,
    input logic [SEL_W-1:0]   route_sel,
    input logic               rev2_en,
    input logic [CNT_W-1:0]   rd_count,
    input logic [N_LINES-1:0] irq_lines,
    input logic               ti_status
);
    // R8
    one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_lines));

    // R2
    tick_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze && tick_en && !(wr_en && !wr_sel)) |=> rd_count == $past(rd_count) + CNT_W'(1));

    // R3
    count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel) |=> rd_count == $past(wr_data));

    // R7
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !(wr_en && !wr_sel)) |=> $stable(rd_count));

    // R6
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel) |=> (irq_lines == '0) && !ti_status);

    // R5
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_lines != '0) && !(wr_en && wr_sel)) |=> irq_lines != '0);

    // R9
    status_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ti_status) |-> $past(rev2_en));

    // R9
    status_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ti_status |-> irq_lines != '0);
endmodule

bind cmp_timer_unit cmp_timer_unit_chk #(.CNT_W(CNT_W), .N_LINES(N_LINES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .freeze   (freeze),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .route_sel(route_sel),
    .rev2_en  (rev2_en),
    .rd_count (rd_count),
    .irq_lines(irq_lines),
    .ti_status(ti_status)
);

// File: tb/cmp_timer_unit_tb.sv
module cmp_timer_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        freeze = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic [2:0]  route_sel = '0;
    logic        rev2_en = 1'b0;
    logic [31:0] rd_count;
    logic [7:0]  irq_lines;
    logic        ti_status;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cmp_timer_unit u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .freeze(freeze),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .route_sel(route_sel), .rev2_en(rev2_en),
        .rd_count(rd_count), .irq_lines(irq_lines), .ti_status(ti_status)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, req, act, exp);
    endtask

    task automatic wr(input logic sel, input logic [31:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        cyc(1);
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        chk_eq("R1 count", rd_count, 32'd1);
        chk_eq("R1 lines", {24'd0, irq_lines}, 32'd0);
        chk_eq("R1 status", {31'd0, ti_status}, 32'd0);
        chk_eq("R10 read port", rd_count, 32'd1);
    endtask

    task automatic t_count();
        wr(1'b1, 32'h8000_0000);
        tick_en = 1'b1; cyc(5); tick_en = 1'b0;
        chk_eq("R2 increment", rd_count, 32'd6);
        cyc(3);
        chk_eq("R2 hold", rd_count, 32'd6);
        wr(1'b0, 32'hFFFF_FFFF);
        tick_en = 1'b1; cyc(1); tick_en = 1'b0;
        chk_eq("R2 wrap", rd_count, 32'd0);
    endtask

    task automatic t_wr_prio();
        tick_en = 1'b1;
        wr(1'b0, 32'd100);
        chk_eq("R3 load beats tick", rd_count, 32'd100);
        cyc(1);
        chk_eq("R3 resume", rd_count, 32'd101);
        tick_en = 1'b0;
    endtask

    task automatic t_match();
        rev2_en = 1'b1; route_sel = 3'd3;
        wr(1'b1, 32'd200);
        wr(1'b0, 32'd198);
        tick_en = 1'b1;
        cyc(2);
        chk_eq("R4 not yet", {24'd0, irq_lines}, 32'd0);
        cyc(1);
        chk_eq("R4 count", rd_count, 32'd201);
        chk_eq("R4 line", {24'd0, irq_lines}, 32'h08);
        chk_eq("R9 status set", {31'd0, ti_status}, 32'd1);
        cyc(3);
        chk_eq("R5 sticky", {24'd0, irq_lines}, 32'h08);
        wr(1'b1, 32'd500);
        chk_eq("R6 ack lines", {24'd0, irq_lines}, 32'd0);
        chk_eq("R6 ack status", {31'd0, ti_status}, 32'd0);
        tick_en = 1'b0;
    endtask

    task automatic t_rev1_route();
        rev2_en = 1'b0; route_sel = 3'd5;
        wr(1'b1, 32'd600);
        wr(1'b0, 32'd598);
        tick_en = 1'b1; cyc(3); tick_en = 1'b0;
        chk_eq("R9 line without status", {24'd0, irq_lines}, 32'h20);
        chk_eq("R9 status clear", {31'd0, ti_status}, 32'd0);
        route_sel = 3'd0;
        cyc(1);
        chk_eq("R8 route moved", {24'd0, irq_lines}, 32'h01);
        wr(1'b1, 32'd650);
        chk_eq("R6 ack", {24'd0, irq_lines}, 32'd0);
    endtask

    task automatic t_same_cycle();
        rev2_en = 1'b1; route_sel = 3'd2;
        wr(1'b1, 32'd700);
        wr(1'b0, 32'd698);
        tick_en = 1'b1; cyc(2);
        chk_eq("R2 at match", rd_count, 32'd700);
        wr(1'b1, 32'd900);
        chk_eq("R6 write wins lines", {24'd0, irq_lines}, 32'd0);
        cyc(2);
        chk_eq("R6 write wins later", {24'd0, irq_lines}, 32'd0);
        chk_eq("R6 write wins status", {31'd0, ti_status}, 32'd0);
        tick_en = 1'b0;
    endtask

    task automatic t_freeze();
        logic [31:0] held;
        freeze = 1'b1; tick_en = 1'b1;
        held = rd_count;
        cyc(3);
        chk_eq("R7 hold", rd_count, held);
        wr(1'b0, 32'd900);
        chk_eq("R7 load while frozen", rd_count, 32'd900);
        cyc(3);
        chk_eq("R7 no match", {24'd0, irq_lines}, 32'd0);
        chk_eq("R7 count still", rd_count, 32'd900);
        freeze = 1'b0;
        cyc(1);
        chk_eq("R7 release count", rd_count, 32'd901);
        chk_eq("R7 release fires", {24'd0, irq_lines}, 32'h04);
        tick_en = 1'b0;
        wr(1'b1, 32'd5000);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_count();
        t_wr_prio();
        t_match();
        t_rev1_route();
        t_same_cycle();
        t_freeze();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule